// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Locking Error Flags

This block receives frames from a single idle-high serial line. A 16x oversampling enable paces it. When it sees a low level on the line, it checks that level again half a bit later. If the line is still low, it treats that as a start bit and samples every later bit at its centre. Data arrives least significant bit first. The frame holds 7 or 8 data bits, an optional parity bit and one or two stop bits. The format inputs are captured when the start bit is first seen.

When a frame is good and the previous word has been taken, the block moves the assembled word into a holding register and raises a ready flag. A read acknowledge lowers that flag.

Three kinds of error are recorded in sticky flags:
- overrun, when a frame completes while the ready flag is still high;
- framing, when the first stop bit is sampled low;
- parity, when the parity check fails.

Each flag has its own clear strobe. While any of the three flags is set, the receiver ignores the line completely. The synchronised line level is also brought out, so a continuous low (a break) can be recognised after a framing error.

Top module: `async_rx`

## Requirements
- R1: After reset, rx_ready, err_ovr, err_frm and err_par are 0, rx_data is 0, and line_level follows the synchronised idle-high line, so it reads 1.
- R2: With cfg_len7=0, eight data bits are taken LSB first. A good frame loads them into rx_data and sets rx_ready.
- R3: With cfg_len7=1, seven data bits are taken LSB first into rx_data[6:0], and rx_data[7] reads 0.
- R4: With cfg_par_en=1, a parity bit follows the data. With cfg_par_odd=0, the data bits plus the parity bit must hold an even number of ones; with cfg_par_odd=1, an odd number. A mismatch sets err_par and does not load rx_data.
- R5: A first stop bit sampled as 0 sets err_frm and does not load rx_data.
- R6: With cfg_two_stop=1, a second stop bit is timed but never checked. A 0 there causes no error.
- R7: A frame completing while rx_ready is 1 sets err_ovr. rx_data keeps the old word and the new word is discarded.
- R8: While any error flag is 1, complete frames on the line change no output. Reception resumes once all flags are cleared.
- R9: Each of clr_ovr, clr_frm and clr_par clears only its own flag. rd_ack clears rx_ready and leaves rx_data unchanged.
- R10: line_level shows the line level two clocks later, including a line held low after a framing error (a break).
- R11: A low pulse shorter than half a bit, gone at the eighth oversample tick after detection, starts no frame.
- R12: The format inputs are captured at start detection. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Two stop bits |
| rd_ack | input | 1 | Clears rx_ready |
| clr_ovr | input | 1 | Clears err_ovr |
| clr_frm | input | 1 | Clears err_frm |
| clr_par | input | 1 | Clears err_par |
| rx_data | output | 8 | Received word |
| rx_ready | output | 1 | Word waiting to be read |
| err_ovr | output | 1 | Sticky overrun flag |
| err_frm | output | 1 | Sticky framing flag |
| err_par | output | 1 | Sticky parity flag |
| line_level | output | 1 | Synchronised line level |

## Verification
A bit counter or sample phase that has slipped shows up within one frame. The received word comes out shifted, or a stop or parity sample lands on a data bit and raises a false error flag. A lock that is never released, or one that leaks, is visible on the very next frame: data is either refused after the clears, or accepted while a flag is still set. A config register that is not held shows as wrongly truncated data on the frame during which the inputs were switched.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } rx_cfg_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import async_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              locked_i,
  input  rx_cfg_t           cfg_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              par_ok_o,
  output logic              stop_ok_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              acc_q, acc_d;
  rx_cfg_t           cfg_q, cfg_d;
  logic              cnt_wrap;
  logic [IDX_W-1:0]  last_idx;

  assign cnt_wrap = (cnt_q == LAST_CNT);
  assign last_idx = cfg_q.len7 ? IDX_W'(DATA_W-2) : IDX_W'(DATA_W-1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    acc_d   = acc_q;
    cfg_d   = cfg_q;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tick_i && !locked_i && !line_i) begin
          state_d = ST_START;
          cnt_d   = '0;
          idx_d   = '0;
          shreg_d = '0;
          acc_d   = 1'b0;
          cfg_d   = cfg_i;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == HALF_CNT) begin
            cnt_d   = '0;
            state_d = line_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          if (cnt_wrap) begin
            cnt_d          = '0;
            shreg_d[idx_q] = line_i;
            acc_d          = acc_q ^ line_i;
            idx_d          = idx_q + 1'b1;
            if (idx_q == last_idx) state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (tick_i) begin
          if (cnt_wrap) begin
            cnt_d   = '0;
            acc_d   = acc_q ^ line_i;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          if (cnt_wrap) begin
            cnt_d   = '0;
            done_o  = 1'b1;
            state_d = cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_STOP2: begin
        if (tick_i) begin
          if (cnt_wrap) begin
            cnt_d   = '0;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      acc_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      acc_q   <= acc_d;
      cfg_q   <= cfg_d;
    end
  end

  assign word_o    = shreg_q;
  assign stop_ok_o = line_i;
  assign par_ok_o  = !cfg_q.par_en || (acc_q == cfg_q.par_odd);

  // R12: the captured format holds for the whole frame
  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> cfg_q == $past(cfg_q));

  // R8: no frame starts while locked
  p_no_start_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && locked_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              par_ok_i,
  input  logic              stop_ok_i,
  input  logic              rd_ack_i,
  input  logic              clr_ovr_i,
  input  logic              clr_frm_i,
  input  logic              clr_par_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o,
  output logic              locked_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic rdy_q, rdy_d, ovr_q, ovr_d, frm_q, frm_d, par_q, par_d;
  logic load, set_ovr, set_frm, set_par;

  always_comb begin
    load    = done_i && stop_ok_i && par_ok_i && !rdy_q;
    set_ovr = done_i && rdy_q;
    set_frm = done_i && !stop_ok_i;
    set_par = done_i && !par_ok_i;
    data_d  = load ? word_i : data_q;
    rdy_d   = load || (rdy_q && !rd_ack_i);
    ovr_d   = set_ovr || (ovr_q && !clr_ovr_i);
    frm_d   = set_frm || (frm_q && !clr_frm_i);
    par_d   = set_par || (par_q && !clr_par_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      ovr_q  <= ovr_d;
      frm_q  <= frm_d;
      par_q  <= par_d;
    end
  end

  assign data_o   = data_q;
  assign ready_o  = rdy_q;
  assign ovr_o    = ovr_q;
  assign frm_o    = frm_q;
  assign par_o    = par_q;
  assign locked_o = ovr_q || frm_q || par_q;

  p_frm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !stop_ok_i) |=> frm_q);

  p_par_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !par_ok_i) |=> par_q);

  p_ovr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && rdy_q) |=> (ovr_q && $stable(data_q)));

  p_clr_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr_i && !done_i) |=> !ovr_q);

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack_i && !done_i) |=> (!rdy_q && $stable(data_q)));
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              cfg_len7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              rd_ack,
  input  logic              clr_ovr,
  input  logic              clr_frm,
  input  logic              clr_par,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_ovr,
  output logic              err_frm,
  output logic              err_par,
  output logic              line_level
);
  logic              line_s, done, par_ok, stop_ok, locked;
  logic [DATA_W-1:0] word;
  rx_cfg_t           cfg;

  assign cfg = '{len7: cfg_len7, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, two_stop: cfg_two_stop};

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rxd), .line_o(line_s)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(os_tick), .line_i(line_s),
    .locked_i(locked), .cfg_i(cfg), .done_o(done), .word_o(word),
    .par_ok_o(par_ok), .stop_ok_o(stop_ok)
  );

  rx_status_regs #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .done_i(done), .word_i(word),
    .par_ok_i(par_ok), .stop_ok_i(stop_ok), .rd_ack_i(rd_ack),
    .clr_ovr_i(clr_ovr), .clr_frm_i(clr_frm), .clr_par_i(clr_par),
    .data_o(rx_data), .ready_o(rx_ready), .ovr_o(err_ovr),
    .frm_o(err_frm), .par_o(err_par), .locked_o(locked)
  );

  assign line_level = line_s;

  // R8: no word is delivered while a flag is pending
  p_lock_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovr || err_frm || err_par) |=> !$rose(rx_ready));
endmodule

// File: tb/tb_async_rx.sv
module tb_async_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic rd_ack = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
  logic [7:0] rx_data;
  logic rx_ready, err_ovr, err_frm, err_par, line_level;

  typedef struct packed {
    logic [7:0] data;
    logic rdy, ovr, frm, par;
  } obs_t;

  int n_chk = 0, n_err = 0;
  obs_t exp_q[$];
  string tag_q[$];
  event frame_ev;

  logic [7:0] m_data = 8'h00;
  logic m_rdy = 0, m_ovr = 0, m_frm = 0, m_par = 0;

  always #5 clk = ~clk;

  async_rx dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rd_ack(rd_ack), .clr_ovr(clr_ovr),
    .clr_frm(clr_frm), .clr_par(clr_par), .rx_data(rx_data),
    .rx_ready(rx_ready), .err_ovr(err_ovr), .err_frm(err_frm),
    .err_par(err_par), .line_level(line_level)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      os_tick = (tc == 3);
      tc = (tc + 1) % 4;
    end
  end

  function automatic obs_t model_now();
    return '{data: m_data, rdy: m_rdy, ovr: m_ovr, frm: m_frm, par: m_par};
  endfunction

  function automatic obs_t dut_now();
    return '{data: rx_data, rdy: rx_ready, ovr: err_ovr, frm: err_frm, par: err_par};
  endfunction

  task automatic chk_obs(input string tag);
    obs_t a, e;
    a = dut_now();
    e = model_now();
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s: got data=%h rdy=%b ovr=%b frm=%b par=%b, want data=%h rdy=%b ovr=%b frm=%b par=%b",
               tag, a.data, a.rdy, a.ovr, a.frm, a.par, e.data, e.rdy, e.ovr, e.frm, e.par);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b want %b", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      obs_t a, e;
      string t;
      @(frame_ev);
      @(negedge clk);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = dut_now();
      n_chk++;
      if (a !== e) begin
        n_err++;
        $display("FAIL %s: got data=%h rdy=%b ovr=%b frm=%b par=%b, want data=%h rdy=%b ovr=%b frm=%b par=%b",
                 t, a.data, a.rdy, a.ovr, a.frm, a.par, e.data, e.rdy, e.ovr, e.frm, e.par);
      end
    end
  end

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic l7, input logic pe,
                            input logic po, input logic badp, input logic sb,
                            input logic ts, input logic s2, input logic flip,
                            input logic holdlow, input string tag);
    logic [7:0] dm;
    logic pb, pok;
    int nb;
    cfg_len7 = l7; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    @(negedge clk);
    nb = l7 ? 7 : 8;
    dm = l7 ? {1'b0, d[6:0]} : d;
    pb = (^dm) ^ po ^ badp;
    if (!(m_ovr || m_frm || m_par)) begin
      pok = !pe || !badp;
      if (m_rdy) m_ovr = 1'b1;
      if (!sb) m_frm = 1'b1;
      if (!pok) m_par = 1'b1;
      if (sb && pok && !m_rdy) begin
        m_data = dm;
        m_rdy = 1'b1;
      end
    end
    exp_q.push_back(model_now());
    tag_q.push_back(tag);
    if (flip) begin
      rxd = 1'b0;
      repeat (40) @(negedge clk);
      cfg_len7 = ~l7;
      repeat (24) @(negedge clk);
    end else begin
      drive_bit(1'b0);
    end
    for (int i = 0; i < nb; i++) drive_bit(dm[i]);
    if (pe) drive_bit(pb);
    drive_bit(sb);
    if (ts) drive_bit(s2);
    drive_bit(holdlow ? 1'b0 : 1'b1);
    ->frame_ev;
    repeat (3) @(negedge clk);
    cfg_len7 = l7;
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
    m_rdy = 1'b0;
  endtask

  task automatic pulse_clr(input int which);
    case (which)
      0: begin clr_ovr = 1'b1; m_ovr = 1'b0; end
      1: begin clr_frm = 1'b1; m_frm = 1'b0; end
      default: begin clr_par = 1'b1; m_par = 1'b0; end
    endcase
    @(negedge clk);
    clr_ovr = 1'b0; clr_frm = 1'b0; clr_par = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout want completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_obs("R1 reset state");
    chk_bit("R1 line idle", line_level, 1'b1);

    send_frame(8'h5A, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R2 8-bit lsb first");
    pulse_ack();
    chk_obs("R9 ack clears ready");

    send_frame(8'h93, 1, 0, 0, 0, 1, 0, 1, 0, 0, "R3 7-bit word");
    pulse_ack();
    send_frame(8'hC3, 0, 1, 0, 0, 1, 0, 1, 0, 0, "R4 even parity ok");
    pulse_ack();
    send_frame(8'h07, 0, 1, 1, 0, 1, 0, 1, 0, 0, "R4 odd parity ok");
    pulse_ack();
    send_frame(8'h55, 0, 1, 0, 1, 1, 0, 1, 0, 0, "R4 parity mismatch");
    send_frame(8'h3C, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R8 locked by parity flag");
    pulse_clr(2);
    chk_obs("R9 clr_par");

    send_frame(8'h81, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 stop bit low");
    pulse_clr(1);
    send_frame(8'h6E, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R6 second stop unchecked");
    pulse_ack();

    send_frame(8'h11, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R7 first word");
    send_frame(8'h22, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R7 overrun keeps data");
    send_frame(8'h33, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R8 locked by overrun");
    pulse_clr(0);
    chk_obs("R9 clr_ovr only");
    pulse_ack();
    send_frame(8'h44, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R8 resumes after clear");
    pulse_ack();

    send_frame(8'h0F, 0, 1, 0, 1, 0, 0, 1, 0, 0, "R5 frame and parity errors");
    pulse_clr(2);
    chk_obs("R9 clr_par keeps frm");
    pulse_clr(1);
    chk_obs("R9 clr_frm");

    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk_obs("R11 glitch ignored");
    send_frame(8'h99, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R11 frame after glitch");
    pulse_ack();

    send_frame(8'h00, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R10 break frame");
    chk_bit("R10 break line low", line_level, 1'b0);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    chk_bit("R10 line back high", line_level, 1'b1);
    pulse_clr(1);

    send_frame(8'hA5, 0, 0, 0, 0, 1, 0, 1, 1, 0, "R12 cfg change mid frame");
    pulse_ack();
    chk_obs("R9 final ack");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule